// File: doc/BRIEF.md
# DDS Serial Command Register Interface

This block sits between a host serial link and a direct digital synthesis oscillator core. The host sends 16-bit command words on a three-wire serial slave port: a serial clock, an active-low select and a data line. Each word carries a command code, a register address and one data byte. The block decodes each complete word and updates a register file. That file holds two 32-bit frequency tuning words, four 12-bit phase offsets, and control bits for frequency select, phase select, sync, selection source, sleep, core reset and clear. Every committed value is driven in parallel to the oscillator core. Nothing can be read back.

Tuning registers are written in two phases. A staging command stores one byte together with the address it is meant for. A later commit command writes a whole 16-bit register half at once, built from the staged byte and the commit command's own byte. The core therefore never sees a half-written tuning word.

The block also picks which frequency register and which phase register the core uses. The choice comes either from two external select pins or from the control bits set over the serial port. The serial lines are treated as asynchronous: they are synchronised and oversampled by the system clock, and the serial clock must run several times slower than the system clock.

Top module: `dds_cmd_if`

## Requirements
- R1: After synchronous reset, all tuning registers read zero. Frequency select, phase select, sync and selection source read 0. Sleep, core reset and clear read 1.
- R2: A word is accepted only if exactly 16 serial-clock falling edges occur while select is low. Data is sampled MSB first on each falling edge, and the word is decoded when select rises. A word with any other number of edges changes no output.
- R3: Word fields are: bits 15:12 command, bits 11:8 address, bits 7:0 data byte. Command 0x3 with an address of 0x0 to 0x7 stages the byte and its address. Command 0x2 with an address of 0x0 to 0x7 commits one 16-bit half. Address bit 2 picks frequency word 0 or 1, and address bit 1 picks the low half (bits 15:0) or high half (bits 31:16). The half becomes {staged byte, data byte}, and all 16 bits change in the same clock cycle.
- R4: A commit finds a match only if a byte is pending and its staged address equals the commit address with bit 0 forced to 1. When there is no match, the upper byte of the half is zero. Every commit consumes the pending byte, so a second commit in a row finds no match.
- R5: Command 0x1 with an address of 0x8 to 0xF stages a phase byte. Command 0x0 with an address of 0x8 to 0xF commits phase register number address[2:1], using the matching rule of R4. The committed value is {staged byte bits 3:0, data byte}.
- R6: Commands 0x6 and 0x7 set frequency select from word bit 11 and phase select from word bits 10:9.
- R7: Commands 0x8 to 0xB set sync from word bit 13 and selection source from word bit 12.
- R8: Commands 0xC to 0xF set sleep from bit 13, core reset from bit 12 and clear from bit 11.
- R9: These words change no output and leave the pending byte untouched: commands 0x4 and 0x5, frequency commands with an address of 0x8 or above, and phase commands with an address below 0x8.
- R10: One clock after selection source is 0, the active selects follow the select pins. When it is 1, they follow the register bits of R6.
- R11: A discarded word (R2) leaves the pending byte and its address unchanged, so a later matching commit still uses that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high, data sampled on falling edge |
| cs_n | input | 1 | Active-low word select |
| mosi | input | 1 | Serial data in, MSB first |
| pin_fsel | input | 1 | External frequency register select |
| pin_psel | input | 2 | External phase register select |
| freq_word0 | output | 32 | Frequency tuning word 0 |
| freq_word1 | output | 32 | Frequency tuning word 1 |
| phase_words | output | 48 | Phase offsets, register i at bits 12i+11:12i |
| fsel_q | output | 1 | Frequency select control bit |
| psel_q | output | 2 | Phase select control bits |
| sync_q | output | 1 | Sync control bit |
| selsrc_q | output | 1 | Selection source control bit |
| sleep_q | output | 1 | Sleep control bit |
| core_reset_q | output | 1 | Core reset control bit |
| clear_q | output | 1 | Clear control bit |
| act_fsel | output | 1 | Active frequency register select |
| act_psel | output | 2 | Active phase register select |

## Verification
The assertions assume two things about the inputs. The select pins are synchronous to the system clock. The serial clock holds each level for at least three system clocks, so that no edge is lost in the synchroniser. The stimulus keeps to both. Serial half periods are four clocks long, mosi is changed only while the serial clock is high, and the select pins are driven at the falling edge of the system clock. Select is held high for several clocks between words, which lets each decoded word reach the outputs before the next word starts.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int CMD_W   = 4;

  typedef enum logic [2:0] {
    K_FREQ,
    K_PHASE,
    K_SEL,
    K_SYNC,
    K_POWER,
    K_NONE
  } cmd_kind_e;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } cmd_word_t;

  function automatic cmd_kind_e classify(input cmd_word_t w);
    cmd_kind_e k;
    if (w.cmd[3:2] == 2'b11)                     k = K_POWER;
    else if (w.cmd[3:2] == 2'b10)                k = K_SYNC;
    else if (w.cmd[3:1] == 3'b011)               k = K_SEL;
    else if (w.cmd[3:1] == 3'b001 && !w.addr[3]) k = K_FREQ;
    else if (w.cmd[3:1] == 3'b000 && w.addr[3])  k = K_PHASE;
    else                                         k = K_NONE;
    return k;
  endfunction
endpackage

// File: rtl/dds_serial_rx.sv
module dds_serial_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  wire sclk_c = sclk_s[SYNC_STAGES-1];
  wire cs_c   = cs_s[SYNC_STAGES-1];
  wire mosi_c = mosi_s[SYNC_STAGES-1];
  wire fall   = sclk_d & ~sclk_c;
  wire cs_up  = ~cs_d & cs_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '1;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sclk_d <= sclk_c;
      cs_d   <= cs_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      word_stb <= 1'b0;
      word_q   <= '0;
    end else begin
      word_stb <= cs_up && (cnt == CNT_FULL);
      if (cs_up) word_q <= shreg;
      if (cs_c) begin
        cnt <= '0;
      end else if (fall) begin
        shreg <= {shreg[WORD_W-2:0], mosi_c};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dds_cmd_regs.sv
module dds_cmd_regs
  import dds_cmd_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 12,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      word_stb,
  input  logic [WORD_W-1:0]         word_q,
  output logic [N_FREQ*FREQ_W-1:0]  freq_flat,
  output logic [N_PHASE*PHASE_W-1:0] phase_flat,
  output logic                      fsel_q,
  output logic [1:0]                psel_q,
  output logic                      sync_q,
  output logic                      selsrc_q,
  output logic                      sleep_q,
  output logic                      core_reset_q,
  output logic                      clear_q
);
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int N_HALF  = N_FREQ * (FREQ_W / HALF_W);
  localparam int HIDX_W  = $clog2(N_HALF);
  localparam int PIDX_W  = $clog2(N_PHASE);
  localparam int NIB_W   = PHASE_W - BYTE_W;

  logic [HALF_W-1:0]  half_mem  [N_HALF];
  logic [PHASE_W-1:0] phase_mem [N_PHASE];

  logic [BYTE_W-1:0] stg_byte;
  logic [ADDR_W-1:0] stg_addr;
  logic              stg_vld;

  cmd_word_t w;
  cmd_kind_e kind;
  logic      is_stage, match;
  logic [BYTE_W-1:0] hi_byte;
  logic [HIDX_W-1:0] hidx;
  logic [PIDX_W-1:0] pidx;

  always_comb begin
    w        = cmd_word_t'(word_q);
    kind     = classify(w);
    is_stage = w.cmd[0];
    match    = stg_vld && (stg_addr == {w.addr[ADDR_W-1:1], 1'b1});
    hi_byte  = match ? stg_byte : '0;
    hidx     = HIDX_W'(w.addr[2:1]);
    pidx     = PIDX_W'(w.addr[2:1]);
  end

  // staging register
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_byte <= '0;
      stg_addr <= '0;
      stg_vld  <= 1'b0;
    end else if (word_stb && (kind == K_FREQ || kind == K_PHASE)) begin
      if (is_stage) begin
        stg_byte <= w.data;
        stg_addr <= w.addr;
        stg_vld  <= 1'b1;
      end else begin
        stg_vld  <= 1'b0;
      end
    end
  end

  // tuning storage, one write port each
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_HALF; i++) half_mem[i] <= '0;
    end else if (word_stb && kind == K_FREQ && !is_stage) begin
      half_mem[hidx] <= {hi_byte, w.data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PHASE; i++) phase_mem[i] <= '0;
    end else if (word_stb && kind == K_PHASE && !is_stage) begin
      phase_mem[pidx] <= {hi_byte[NIB_W-1:0], w.data};
    end
  end

  // control bits
  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q       <= 1'b0;
      psel_q       <= 2'b00;
      sync_q       <= 1'b0;
      selsrc_q     <= 1'b0;
      sleep_q      <= 1'b1;
      core_reset_q <= 1'b1;
      clear_q      <= 1'b1;
    end else if (word_stb) begin
      case (kind)
        K_SEL: begin
          fsel_q <= word_q[11];
          psel_q <= word_q[10:9];
        end
        K_SYNC: begin
          sync_q   <= word_q[13];
          selsrc_q <= word_q[12];
        end
        K_POWER: begin
          sleep_q      <= word_q[13];
          core_reset_q <= word_q[12];
          clear_q      <= word_q[11];
        end
        default: ;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_HALF; gi++) begin : g_half
      assign freq_flat[gi*HALF_W +: HALF_W] = half_mem[gi];
    end
    for (gi = 0; gi < N_PHASE; gi++) begin : g_phase
      assign phase_flat[gi*PHASE_W +: PHASE_W] = phase_mem[gi];
    end
  endgenerate
endmodule

// File: rtl/dds_sel_mux.sv
module dds_sel_mux #(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selsrc,
  input  logic              reg_fsel,
  input  logic [PSEL_W-1:0] reg_psel,
  input  logic              pin_fsel,
  input  logic [PSEL_W-1:0] pin_psel,
  output logic              act_fsel,
  output logic [PSEL_W-1:0] act_psel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_fsel <= 1'b0;
      act_psel <= '0;
    end else if (selsrc) begin
      act_fsel <= reg_fsel;
      act_psel <= reg_psel;
    end else begin
      act_fsel <= pin_fsel;
      act_psel <= pin_psel;
    end
  end
endmodule

// File: rtl/dds_cmd_if.sv
module dds_cmd_if
  import dds_cmd_pkg::*;
#(
  parameter int FREQ_W      = 32,
  parameter int PHASE_W     = 12,
  parameter int N_PHASE     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       mosi,
  input  logic                       pin_fsel,
  input  logic [1:0]                 pin_psel,
  output logic [FREQ_W-1:0]          freq_word0,
  output logic [FREQ_W-1:0]          freq_word1,
  output logic [N_PHASE*PHASE_W-1:0] phase_words,
  output logic                       fsel_q,
  output logic [1:0]                 psel_q,
  output logic                       sync_q,
  output logic                       selsrc_q,
  output logic                       sleep_q,
  output logic                       core_reset_q,
  output logic                       clear_q,
  output logic                       act_fsel,
  output logic [1:0]                 act_psel
);
  localparam int N_FREQ = 2;

  logic              word_stb;
  logic [WORD_W-1:0] word_q;
  logic [N_FREQ*FREQ_W-1:0] freq_flat;

  dds_serial_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .word_stb(word_stb), .word_q(word_q)
  );

  dds_cmd_regs #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .N_FREQ(N_FREQ),
                 .N_PHASE(N_PHASE)) u_regs (
    .clk(clk), .rst(rst), .word_stb(word_stb), .word_q(word_q),
    .freq_flat(freq_flat), .phase_flat(phase_words),
    .fsel_q(fsel_q), .psel_q(psel_q), .sync_q(sync_q), .selsrc_q(selsrc_q),
    .sleep_q(sleep_q), .core_reset_q(core_reset_q), .clear_q(clear_q)
  );

  dds_sel_mux #(.PSEL_W(2)) u_mux (
    .clk(clk), .rst(rst), .selsrc(selsrc_q),
    .reg_fsel(fsel_q), .reg_psel(psel_q),
    .pin_fsel(pin_fsel), .pin_psel(pin_psel),
    .act_fsel(act_fsel), .act_psel(act_psel)
  );

  assign freq_word0 = freq_flat[FREQ_W-1:0];
  assign freq_word1 = freq_flat[2*FREQ_W-1:FREQ_W];
endmodule

// File: rtl/dds_cmd_chk.sv
module dds_cmd_chk (
  input logic        clk,
  input logic        rst,
  input logic        word_stb,
  input logic [31:0] freq_word0,
  input logic [31:0] freq_word1,
  input logic [47:0] phase_words,
  input logic        selsrc_q,
  input logic        fsel_q,
  input logic [1:0]  psel_q,
  input logic        pin_fsel,
  input logic [1:0]  pin_psel,
  input logic        sleep_q,
  input logic        core_reset_q,
  input logic        clear_q,
  input logic        act_fsel,
  input logic [1:0]  act_psel
);
  // R1
  reset_power_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ({sleep_q, core_reset_q, clear_q} == 3'b111));

  // R3
  freq0_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_word0) |-> $past(word_stb));

  // R3
  freq1_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_word1) |-> $past(word_stb));

  // R5
  phase_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_words) |-> $past(word_stb));

  // R10
  pin_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(selsrc_q)) |-> ({act_fsel, act_psel} == $past({pin_fsel, pin_psel})));

  // R10
  reg_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(selsrc_q)) |-> ({act_fsel, act_psel} == $past({fsel_q, psel_q})));
endmodule

bind dds_cmd_if dds_cmd_chk u_chk (
  .clk(clk), .rst(rst), .word_stb(word_stb),
  .freq_word0(freq_word0), .freq_word1(freq_word1), .phase_words(phase_words),
  .selsrc_q(selsrc_q), .fsel_q(fsel_q), .psel_q(psel_q),
  .pin_fsel(pin_fsel), .pin_psel(pin_psel),
  .sleep_q(sleep_q), .core_reset_q(core_reset_q), .clear_q(clear_q),
  .act_fsel(act_fsel), .act_psel(act_psel)
);

// File: tb/sim_dds_cmd_if.sv
module sim_dds_cmd_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic pin_fsel = 1'b0;
  logic [1:0] pin_psel = 2'b00;
  logic [31:0] freq_word0, freq_word1;
  logic [47:0] phase_words;
  logic fsel_q, sync_q, selsrc_q, sleep_q, core_reset_q, clear_q, act_fsel;
  logic [1:0] psel_q, act_psel;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dds_cmd_if u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .pin_fsel(pin_fsel), .pin_psel(pin_psel),
    .freq_word0(freq_word0), .freq_word1(freq_word1), .phase_words(phase_words),
    .fsel_q(fsel_q), .psel_q(psel_q), .sync_q(sync_q), .selsrc_q(selsrc_q),
    .sleep_q(sleep_q), .core_reset_q(core_reset_q), .clear_q(clear_q),
    .act_fsel(act_fsel), .act_psel(act_psel)
  );

  // reference model state
  logic [15:0] m_half [4];
  logic [11:0] m_ph [4];
  logic m_fsel, m_sync, m_selsrc;
  logic [1:0] m_psel;
  logic [2:0] m_pwr;
  logic m_stv;
  logic [3:0] m_sta;
  logic [7:0] m_stb;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_half[i] = '0; m_ph[i] = '0; end
    m_fsel = 0; m_sync = 0; m_selsrc = 0; m_psel = 0; m_pwr = 3'b111;
    m_stv = 0; m_sta = 0; m_stb = 0;
  endtask

  task automatic model_word(input logic [15:0] w);
    logic [3:0] c, a; logic [7:0] d; logic [7:0] hi;
    c = w[15:12]; a = w[11:8]; d = w[7:0];
    hi = (m_stv && m_sta == {a[3:1], 1'b1}) ? m_stb : 8'h00;
    if (c >= 4'hC) m_pwr = w[13:11];
    else if (c >= 4'h8) begin m_sync = w[13]; m_selsrc = w[12]; end
    else if (c == 4'h6 || c == 4'h7) begin m_fsel = w[11]; m_psel = w[10:9]; end
    else if ((c == 4'h3 && a < 8) || (c == 4'h1 && a >= 8)) begin
      m_stv = 1; m_sta = a; m_stb = d;
    end else if (c == 4'h2 && a < 8) begin
      m_half[a[2:1]] = {hi, d}; m_stv = 0;
    end else if (c == 4'h0 && a >= 8) begin
      m_ph[a[2:1]] = {hi[3:0], d}; m_stv = 0;
    end
  endtask

  function automatic logic [31:0] exp_f(input int n);
    return {m_half[2*n+1], m_half[2*n]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [2:0] ea;
    ea = m_selsrc ? {m_fsel, m_psel} : {pin_fsel, pin_psel};
    chk({tag, " freq0"}, 64'(freq_word0), 64'(exp_f(0)));
    chk({tag, " freq1"}, 64'(freq_word1), 64'(exp_f(1)));
    chk({tag, " phase"}, 64'(phase_words), 64'({m_ph[3], m_ph[2], m_ph[1], m_ph[0]}));
    chk({tag, " ctrl"}, 64'({fsel_q, psel_q, sync_q, selsrc_q, sleep_q, core_reset_q, clear_q}),
        64'({m_fsel, m_psel, m_sync, m_selsrc, m_pwr}));
    chk({tag, " R10 act"}, 64'({act_fsel, act_psel}), 64'(ea));
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send n bits of v, MSB first; accepted by model only when n == 16
  task automatic send_bits(input logic [16:0] v, input int n);
    wclk(4);
    cs_n = 1'b0;
    wclk(4);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      wclk(4);
      sclk = 1'b0;
      wclk(4);
      sclk = 1'b1;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(12);
    if (n == 16) model_word(v[15:0]);
  endtask

  task automatic send(input logic [15:0] w);
    send_bits({1'b0, w}, 16);
  endtask

  task automatic set_pins(input logic [2:0] p);
    @(negedge clk);
    {pin_fsel, pin_psel} = p;
    wclk(3);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b0, b1, b2, b3;
    void'($urandom(32'h5eed_0c0d));
    model_reset();
    wclk(5);
    rst = 1'b0;
    wclk(3);
    // R1 reset state
    chk_all("R1 reset");

    // R3 full frequency word 0 sequence
    send(16'h3_3_12); send(16'h2_2_34); send(16'h3_1_56); send(16'h2_0_78);
    chk("R3 freq0 value", 64'(freq_word0), 64'h12345678);
    chk_all("R3 seq");
    // R3 frequency word 1 high half only
    send(16'h3_7_AB); send(16'h2_6_CD);
    chk("R3 freq1 high half", 64'(freq_word1), 64'hABCD0000);

    // R4 mismatched commit gives zero upper byte
    send(16'h3_5_EE); send(16'h2_6_11);
    chk("R4 mismatch", 64'(freq_word1), 64'h00110000);
    // R4 second commit finds nothing pending
    send(16'h3_1_99); send(16'h2_0_22); send(16'h2_0_33);
    chk("R4 consumed", 64'(freq_word0), 64'h12340033);

    // R5 phase commit keeps only low nibble of staged byte
    send(16'h1_B_F7); send(16'h0_A_C4);
    chk("R5 phase1", 64'(phase_words[23:12]), 64'h7C4);
    chk_all("R5");

    // R11 short word keeps the pending byte
    send(16'h1_F_05);
    send_bits({1'b0, 16'h0_E_FF}, 9);
    send_bits({1'b0, 16'hC000}, 15);
    chk_all("R11 short words ignored");
    send(16'h0_E_66);
    chk("R11 pending survives", 64'(phase_words[47:36]), 64'h566);
    // R2 long word discarded
    send_bits({16'h6E00, 1'b1}, 17);
    chk_all("R2 17 edges ignored");

    // R9 ignored commands leave pending byte
    send(16'h3_3_AA);
    send(16'h4_2_55); send(16'h5_2_55); send(16'h2_9_55); send(16'h0_2_55);
    chk_all("R9 ignored");
    send(16'h2_2_01);
    chk("R9 pending survives", 64'(freq_word0), 64'hAA010033);

    // R6 select command, R7 selection source, R10 mux
    set_pins(3'b110);
    send(16'h6A00);
    chk("R6 sel", 64'({fsel_q, psel_q}), 64'b101);
    chk_all("R10 pins");
    send(16'h9000);
    chk("R7 selsrc", 64'({sync_q, selsrc_q}), 64'b01);
    chk_all("R10 regs");
    send(16'hA000);
    chk("R7 sync", 64'({sync_q, selsrc_q}), 64'b10);
    // R8 power bits
    send(16'hC000);
    chk("R8 enable", 64'({sleep_q, core_reset_q, clear_q}), 64'b000);
    send(16'hD800);
    chk("R8 reset+clear", 64'({sleep_q, core_reset_q, clear_q}), 64'b011);

    // random mix
    for (int it = 0; it < 220; it++) begin
      int r, n, p;
      r = $urandom % 8;
      if ($urandom % 6 == 0) set_pins(3'($urandom));
      case (r)
        0, 1, 2: begin
          n = $urandom % 2;
          b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom); b3 = 8'($urandom);
          send({4'h3, 4'(n*4+3), b3}); send({4'h2, 4'(n*4+2), b2});
          send({4'h3, 4'(n*4+1), b1}); send({4'h2, 4'(n*4), b0});
          chk("R3 random freq", 64'(n ? freq_word1 : freq_word0), 64'({b3, b2, b1, b0}));
        end
        3: begin
          p = $urandom % 4;
          b1 = 8'($urandom); b0 = 8'($urandom);
          send({4'h1, 4'(8+2*p+1), b1}); send({4'h0, 4'(8+2*p), b0});
          chk("R5 random phase", 64'(phase_words[p*12 +: 12]), 64'({b1[3:0], b0}));
        end
        4: send({3'b011, 13'($urandom)});
        5: send({1'b1, 15'($urandom)});
        6: send(16'($urandom));
        default: begin
          n = ($urandom % 2) ? 17 : 1 + ($urandom % 15);
          send_bits(17'($urandom), n);
        end
      endcase
      chk_all("R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule